// File: doc/BRIEF.md
# Event Counter Bank

This block is a small bank of 32-bit event counters that sits next to a processor pipeline and is reached through a simple word-addressed register port. Each counter owns a value register, a control register and a status register. One global register holds a master enable that gates every counter at once. The pipeline delivers its events as a parallel bus made of groups of 16 sub-event lines. Each counter picks one group and a 16-bit sub-event mask. It advances by one on every clock in which at least one selected sub-event is active, provided the current privilege level passes its filter.

Software preloads a counter with the negated sample period. On the wrap from all-ones to zero the counter latches a sticky overflow flag. If the counter's interrupt enable is set, it also latches an interrupt flag. The shared interrupt output stays high while any interrupt flag is set. Status bits are cleared by writing ones, so writing back a value just read acknowledges everything that was pending. One group code does not select pipeline events: it makes a counter advance on each overflow of the counter one index below it, so two counters act as a 64-bit counter.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is low.
- R2: Register map, word aligned:
  - global register at 0x1000;
  - value of counter i at 0x1080+4i;
  - control of counter i at 0x1100+4i;
  - status of counter i at 0x1180+4i.

  A value register reads back the last word written to it. A control register stores only bits 0, 3, 7:4, 12:8 and 31:16, so writing all ones reads back 0xFFFF1FF9. Reads of any other offset, of a counter index at or above the counter count, or of an unaligned address return zero.
- R3: When global bit 0 is clear, no counter changes, whatever its control register holds.
- R4: Group 0 with mask bit 0 set counts every clock. After a write that sets the global enable, the counter advances by one on each following rising edge, up to and including the edge that applies a write clearing the enable.
- R5: Sub-event b of group g is `evt_bus[16*g+b]`, with g taken from control bits 12:8. A counter advances by exactly one per cycle in which any sub-event of its group whose control bit 16+b is set is high. Active sub-events that are unmasked, or that belong to other groups, have no effect.
- R6: Privilege filter:
  - a counter advances only when `priv_level` is less than or equal to control bits 7:4;
  - when `priv_level` is 0, control bit 3 must also be set.
- R7: When a counter advances from 0xFFFFFFFF it becomes 0 and status bit 0 is set. The bit stays set until it is cleared.
- R8: Status bit 4 is set on a wrap only when control bit 0 is set. Otherwise it stays clear.
- R9: Writing a status register clears each bit written as 1 and keeps the others. `irq_out` is high exactly while some counter's status bit 4 is set.
- R10: A counter with group code 1 ignores the event bus. It advances once on each cycle in which the counter one index below it wraps, so a carry passes into the upper counter on the same edge.
- R11: Writing zero to a control register stops that counter. The counter keeps the value it had at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 13 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_bus | input | NUM_GROUPS*16 | Sub-event lines, 16 per group |
| priv_level | input | 4 | Current privilege level, 0 is kernel |
| irq_out | output | 1 | Shared overflow interrupt |

## Verification
The hardest state to reach from the ports is a carry into a chained counter. The lower counter has to wrap on the same edge that the upper one samples its chain input, and that takes four billion events unless the lower counter is preloaded. The bench writes 0xFFFFFFFF into the lower counter and a small value into the upper one, selects group code 1 for the upper counter, then pulses one event line for a single cycle. It checks both values and the sticky flag. Interrupt acknowledgement is driven the same way, by preloading a counter two events below the wrap and then clearing its status bits one at a time.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 32;
  localparam int SUB_W  = 16;
  localparam int GRP_W  = 5;
  localparam int LVL_W  = 4;

  // address pages (addr[12:7])
  localparam logic [5:0] PAGE_GLB = 6'h20;
  localparam logic [5:0] PAGE_VAL = 6'h21;
  localparam logic [5:0] PAGE_CTL = 6'h22;
  localparam logic [5:0] PAGE_STS = 6'h23;

  localparam logic [GRP_W-1:0] GRP_CYCLE = 5'd0;
  localparam logic [GRP_W-1:0] GRP_CHAIN = 5'd1;

  typedef struct packed {
    logic [SUB_W-1:0] mask;
    logic [2:0]       rsv_hi;
    logic [GRP_W-1:0] grp;
    logic [LVL_W-1:0] lvl;
    logic             kern;
    logic [1:0]       rsv_lo;
    logic             inten;
  } ctl_t;

  localparam logic [DATA_W-1:0] CTL_WMASK = 32'hFFFF_1FF9;

endpackage

// File: rtl/pmu_reg_decode.sv
module pmu_reg_decode
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_glb,
  output logic              hit_val,
  output logic              hit_ctl,
  output logic              hit_sts,
  output logic [IDX_W-1:0]  idx
);

  logic [5:0] page;
  logic [4:0] slot;
  logic       aligned;
  logic       slot_ok;

  always_comb begin
    page    = addr[12:7];
    slot    = addr[6:2];
    aligned = (addr[1:0] == 2'b00);
    slot_ok = (int'(slot) < NUM_CTR);
    idx     = slot[IDX_W-1:0];
    hit_glb = aligned && (page == PAGE_GLB) && (slot == 5'd0);
    hit_val = aligned && (page == PAGE_VAL) && slot_ok;
    hit_ctl = aligned && (page == PAGE_CTL) && slot_ok;
    hit_sts = aligned && (page == PAGE_STS) && slot_ok;
  end

endmodule

// File: rtl/pmu_event_match.sv
module pmu_event_match
  import pmu_pkg::*;
#(
  parameter int NUM_GROUPS = 16
) (
  input  logic [NUM_GROUPS*SUB_W-1:0] evt_bus,
  input  logic [GRP_W-1:0]            grp,
  input  logic [SUB_W-1:0]            mask,
  input  logic [LVL_W-1:0]            lvl,
  input  logic                        kern,
  input  logic [LVL_W-1:0]            priv,
  input  logic                        glb_en,
  input  logic                        chain_in,
  output logic                        inc
);

  logic [SUB_W-1:0] sel_ev;
  logic             hit;
  logic             priv_ok;

  always_comb begin
    sel_ev = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp == GRP_W'(g)) begin
        sel_ev = evt_bus[g*SUB_W +: SUB_W];
      end
    end
    if (grp == GRP_CYCLE) begin
      sel_ev[0] = 1'b1;
    end
    if (grp == GRP_CHAIN) begin
      hit = chain_in;
    end else begin
      hit = |(sel_ev & mask);
    end
    priv_ok = (priv <= lvl) && ((priv != '0) || kern);
    inc     = glb_en && priv_ok && hit;
  end

endmodule

// File: rtl/pmu_counter_slice.sv
module pmu_counter_slice
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              wr_val,
  input  logic              wr_ctl,
  input  logic              wr_sts,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_q,
  output ctl_t              ctl_q,
  output logic              ovf_q,
  output logic              irqf_q,
  output logic              wrap
);

  logic [DATA_W-1:0] cnt_d;
  ctl_t              ctl_d;
  logic              ovf_d;
  logic              irqf_d;
  logic              cnt_en;
  logic              ctl_en;
  logic              sts_en;

  // next state
  always_comb begin
    wrap   = inc && !wr_val && (cnt_q == '1);
    cnt_en = wr_val || inc;
    cnt_d  = wr_val ? wdata : (cnt_q + 1'b1);
    ctl_en = wr_ctl;
    ctl_d  = ctl_t'(wdata & CTL_WMASK);
    sts_en = wrap || wr_sts;
    ovf_d  = wrap || (ovf_q && !(wr_sts && wdata[0]));
    irqf_d = (wrap && ctl_q.inten) || (irqf_q && !(wr_sts && wdata[4]));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      irqf_q <= 1'b0;
    end else if (sts_en) begin
      ovf_q  <= ovf_d;
      irqf_q <= irqf_d;
    end
  end

endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import pmu_pkg::*;
#(
  parameter int NUM_CTR    = 4,
  parameter int NUM_GROUPS = 16,
  localparam int IDX_W     = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int EVT_W     = NUM_GROUPS * SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_bus,
  input  logic [LVL_W-1:0]  priv_level,
  output logic              irq_out
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  // decode
  logic             hit_glb, hit_val, hit_ctl, hit_sts;
  logic [IDX_W-1:0] idx;

  pmu_reg_decode #(.NUM_CTR(NUM_CTR)) u_dec (
    .addr    (reg_addr),
    .hit_glb (hit_glb),
    .hit_val (hit_val),
    .hit_ctl (hit_ctl),
    .hit_sts (hit_sts),
    .idx     (idx)
  );

  // global enable
  logic glb_en, glb_en_d, glb_wr;

  always_comb begin
    glb_wr   = reg_wr && hit_glb;
    glb_en_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      glb_en <= 1'b0;
    end else if (glb_wr) begin
      glb_en <= glb_en_d;
    end
  end

  // counters
  logic [NUM_CTR-1:0][DATA_W-1:0] cnt_q;
  ctl_t [NUM_CTR-1:0]             ctl_q;
  logic [NUM_CTR-1:0]             ovf_q;
  logic [NUM_CTR-1:0]             irqf_q;
  logic [NUM_CTR-1:0]             wrap;
  logic [NUM_CTR-1:0]             inc;
  logic [NUM_CTR-1:0]             chain_in;
  logic [NUM_CTR-1:0]             inten;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic sel;
    assign sel = (idx == IDX_W'(i));

    if (i == 0) begin : g_base
      assign chain_in[i] = 1'b0;
    end else begin : g_link
      assign chain_in[i] = wrap[i-1];
    end

    pmu_event_match #(.NUM_GROUPS(NUM_GROUPS)) u_match (
      .evt_bus  (evt_bus),
      .grp      (ctl_q[i].grp),
      .mask     (ctl_q[i].mask),
      .lvl      (ctl_q[i].lvl),
      .kern     (ctl_q[i].kern),
      .priv     (priv_level),
      .glb_en   (glb_en),
      .chain_in (chain_in[i]),
      .inc      (inc[i])
    );

    pmu_counter_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .inc    (inc[i]),
      .wr_val (reg_wr && hit_val && sel),
      .wr_ctl (reg_wr && hit_ctl && sel),
      .wr_sts (reg_wr && hit_sts && sel),
      .wdata  (reg_wdata),
      .cnt_q  (cnt_q[i]),
      .ctl_q  (ctl_q[i]),
      .ovf_q  (ovf_q[i]),
      .irqf_q (irqf_q[i]),
      .wrap   (wrap[i])
    );

    assign inten[i] = ctl_q[i].inten;
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit_glb) begin
      reg_rdata = {{(DATA_W-1){1'b0}}, glb_en};
    end else if (hit_val) begin
      reg_rdata = cnt_q[idx];
    end else if (hit_ctl) begin
      reg_rdata = ctl_q[idx];
    end else if (hit_sts) begin
      reg_rdata = {27'd0, irqf_q[idx], 3'd0, ovf_q[idx]};
    end
  end

  assign irq_out = |irqf_q;

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int NUM_CTR = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic                     glb_en,
  input logic [NUM_CTR-1:0]       inc,
  input logic [NUM_CTR-1:0]       ovf_q,
  input logic [NUM_CTR-1:0]       irqf_q,
  input logic [NUM_CTR-1:0]       inten,
  input logic [NUM_CTR-1:0][31:0] cnt_q,
  input logic                     irq_out
);

  a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !reg_wr) |=> $stable(cnt_q));

  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !reg_wr) |=> irq_out);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[i] && !reg_wr) |=> (cnt_q[i] == $past(cnt_q[i]) + 32'd1));

    a_r7_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[i] && !reg_wr && (cnt_q[i] == 32'hFFFF_FFFF)) |=> ovf_q[i]);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[i] && !reg_wr) |=> ovf_q[i]);

    a_r8_no_irq_flag_unless_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!irqf_q[i] && !inten[i]) |=> !irqf_q[i]);
  end

endmodule

bind evt_counter_bank pmu_checker #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .reg_wr  (reg_wr),
  .glb_en  (glb_en),
  .inc     (inc),
  .ovf_q   (ovf_q),
  .irqf_q  (irqf_q),
  .inten   (inten),
  .cnt_q   (cnt_q),
  .irq_out (irq_out)
);

// File: tb/sim_evt_counter_bank.sv
module sim_evt_counter_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTR    = 4;
  localparam int NUM_GROUPS = 16;

  logic                       clk;
  logic                       rst_n;
  logic                       reg_wr;
  logic [12:0]                reg_addr;
  logic [31:0]                reg_wdata;
  logic [31:0]                reg_rdata;
  logic [NUM_GROUPS*16-1:0]   evt_bus;
  logic [3:0]                 priv_level;
  logic                       irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  evt_counter_bank #(.NUM_CTR(NUM_CTR), .NUM_GROUPS(NUM_GROUPS)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .evt_bus    (evt_bus),
    .priv_level (priv_level),
    .irq_out    (irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [12:0] a_val(int i); return 13'(32'h1080 + 4*i); endfunction
  function automatic logic [12:0] a_ctl(int i); return 13'(32'h1100 + 4*i); endfunction
  function automatic logic [12:0] a_sts(int i); return 13'(32'h1180 + 4*i); endfunction
  localparam logic [12:0] A_GLB = 13'h1000;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks are entered and left just after a falling edge
  task automatic wr(logic [12:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(int g, logic [15:0] bits, int n);
    evt_bus = '0;
    evt_bus[g*16 +: 16] = bits;
    repeat (n) @(negedge clk);
    evt_bus = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_GLB, d);    check("R1 global", d, 0);
    rd(a_val(0), d); check("R1 value0", d, 0);
    rd(a_ctl(3), d); check("R1 ctl3", d, 0);
    rd(a_sts(1), d); check("R1 sts1", d, 0);
    check("R1 irq", 32'(irq_out), 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(a_val(2), 32'hDEAD_BEEF);
    rd(a_val(2), d); check("R2 value readback", d, 32'hDEAD_BEEF);
    wr(a_ctl(3), 32'hFFFF_FFFF);
    rd(a_ctl(3), d); check("R2 ctl field mask", d, 32'hFFFF_1FF9);
    wr(a_ctl(3), 0);
    rd(13'h1004, d); check("R2 unmapped global+4", d, 0);
    rd(a_val(NUM_CTR), d); check("R2 index out of range", d, 0);
    rd(13'h108A, d); check("R2 unaligned", d, 0);
  endtask

  task automatic t_enable_gate;
    logic [31:0] d;
    wr(a_val(0), 0);
    wr(a_ctl(0), 32'h0001_00F8);
    repeat (10) @(negedge clk);
    rd(a_val(0), d); check("R3 no count with master off", d, 0);
  endtask

  task automatic t_cycles;
    logic [31:0] d;
    wr(A_GLB, 1);
    repeat (9) @(negedge clk);
    wr(A_GLB, 0);
    rd(a_val(0), d); check("R4 cycle count", d, 10);
    wr(a_ctl(0), 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(a_val(1), 0);
    wr(a_ctl(1), 32'h0005_03F8);
    wr(A_GLB, 1);
    pulse(3, 16'h0002, 3);
    pulse(4, 16'h0001, 2);
    rd(a_val(1), d); check("R5 unmasked and other group ignored", d, 0);
    pulse(3, 16'h0001, 2);
    pulse(3, 16'h0005, 1);
    pulse(3, 16'h0004, 2);
    rd(a_val(1), d); check("R5 masked OR count", d, 5);
    wr(a_ctl(1), 0);
    wr(A_GLB, 0);
  endtask

  task automatic t_priv;
    logic [31:0] d;
    wr(a_val(0), 0);
    wr(a_ctl(0), 32'h0001_0320);
    wr(A_GLB, 1);
    priv_level = 3; pulse(3, 16'h0001, 2);
    priv_level = 0; pulse(3, 16'h0001, 2);
    rd(a_val(0), d); check("R6 above level and kernel blocked", d, 0);
    priv_level = 1; pulse(3, 16'h0001, 3);
    priv_level = 2; pulse(3, 16'h0001, 1);
    rd(a_val(0), d); check("R6 at or below level", d, 4);
    wr(a_ctl(0), 32'h0001_0328);
    priv_level = 0; pulse(3, 16'h0001, 2);
    rd(a_val(0), d); check("R6 kernel with kernel bit", d, 6);
    priv_level = 1;
    wr(a_ctl(0), 0);
    wr(A_GLB, 0);
  endtask

  task automatic t_overflow_irq;
    logic [31:0] d;
    wr(a_val(0), 32'hFFFF_FFFE);
    wr(a_ctl(0), 32'h0001_03F9);
    wr(A_GLB, 1);
    pulse(3, 16'h0001, 2);
    rd(a_val(0), d); check("R7 wrap to zero", d, 0);
    rd(a_sts(0), d); check("R8 flags with irq enable", d, 32'h11);
    check("R9 irq high", 32'(irq_out), 1);
    wr(a_sts(0), 32'h01);
    rd(a_sts(0), d); check("R9 clear bit0 only", d, 32'h10);
    check("R9 irq held", 32'(irq_out), 1);
    wr(a_sts(0), 32'h10);
    rd(a_sts(0), d); check("R9 clear bit4", d, 0);
    check("R9 irq low", 32'(irq_out), 0);
    wr(a_ctl(0), 0);
    // no interrupt enable
    wr(a_val(2), 32'hFFFF_FFFF);
    wr(a_ctl(2), 32'h0001_03F8);
    pulse(3, 16'h0001, 1);
    rd(a_sts(2), d); check("R8 no irq flag without enable", d, 32'h01);
    check("R8 irq stays low", 32'(irq_out), 0);
    repeat (3) @(negedge clk);
    rd(a_sts(2), d); check("R7 sticky", d, 32'h01);
    wr(a_sts(2), d);
    rd(a_sts(2), d); check("R9 write-back clears", d, 0);
    wr(a_ctl(2), 0);
    wr(A_GLB, 0);
  endtask

  task automatic t_chain;
    logic [31:0] d;
    wr(a_val(0), 32'hFFFF_FFFF);
    wr(a_ctl(0), 32'h0001_03F8);
    wr(a_val(1), 5);
    wr(a_ctl(1), 32'h0000_01F8);
    wr(A_GLB, 1);
    pulse(3, 16'h0001, 1);
    rd(a_val(0), d); check("R10 lower wrapped", d, 0);
    rd(a_val(1), d); check("R10 carry into upper", d, 6);
    pulse(3, 16'h0001, 4);
    rd(a_val(1), d); check("R10 upper ignores plain events", d, 6);
    wr(a_sts(0), 32'h11);
    wr(a_ctl(0), 0);
    wr(a_ctl(1), 0);
    wr(A_GLB, 0);
  endtask

  task automatic t_stop;
    logic [31:0] d, v;
    wr(a_val(3), 100);
    wr(a_ctl(3), 32'h0001_00F8);
    wr(A_GLB, 1);
    repeat (4) @(negedge clk);
    wr(a_ctl(3), 0);
    rd(a_val(3), v); check("R11 counted before stop", v, 105);
    repeat (6) @(negedge clk);
    rd(a_val(3), d); check("R11 value held after stop", d, v);
    wr(A_GLB, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_bus = '0; priv_level = 4'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_enable_gate();
    t_cycles();
    t_mask();
    t_priv();
    t_overflow_irq();
    t_chain();
    t_stop();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule